// File: doc/BRIEF.md
# Effective Address Generation Unit

This block works out the memory operand address for a processor with a 24-bit address space. It covers five addressing forms. Two step an address register: post-increment and pre-decrement. Three take the address from an absolute field of 8, 16 or 24 bits. A flag selects between a full 24-bit space and a reduced 16-bit space.

The block holds eight 32-bit address registers. Each auto-stepping request reads one register and writes the stepped value back into it at the same clock edge. The next request therefore sees the updated value. A separate load port lets a surrounding pipeline seed the registers. All results are registered and appear one cycle after the request.

Top module: `ea_unit`

## Requirements
- R1: After reset `ea_valid`, `ea`, `wb_strobe`, `wb_value` and `misalign` are all zero, and every address register reads as zero.
- R2: Mode 0 (post-increment) outputs the low 24 bits of the register as it was before the update. It writes back the register plus the step.
- R3: The step is taken from `size`. Code 0 (byte) gives 1, code 1 (word) gives 2, and codes 2 (longword) and 3 give 4.
- R4: Mode 1 (pre-decrement) writes back the register minus the step. It outputs the low 24 bits of that new value as the address.
- R5: The stepping works on all 32 register bits and wraps modulo 2^32.
- R6: `misalign` is set only for an auto-stepping request whose size is not byte, in two cases. For post-increment, the register value before the step is odd. For pre-decrement, the stepped result is odd.
- R7: Mode 2 (8-bit absolute) takes the field's low 8 bits and fills every bit above them with ones.
- R8: Mode 3 (16-bit absolute) sign-extends the field's low 16 bits from bit 15 when `wide_space` is 1.
- R9: Mode 4 (24-bit absolute) passes the 24-bit field through unchanged when `wide_space` is 1. Modes 5 to 7 behave the same as mode 4.
- R10: When `wide_space` is 0, bits 23:16 of `ea` are zero for every mode. Register writeback still keeps all 32 bits.
- R11: `wb_strobe` is high for exactly one cycle after each accepted request in mode 0 or 1. It stays low after absolute modes and after idle cycles.
- R12: A request reads the value written by the previous request, or by the load port, to the same register.
- R13: Results appear on the outputs in the cycle after `req_valid` is high, with `ea_valid` high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request accepted this cycle |
| req_mode | input | 3 | Addressing form (0 post-inc, 1 pre-dec, 2 abs8, 3 abs16, 4 abs24) |
| req_size | input | 2 | Access size code |
| req_reg | input | 3 | Address register index |
| req_field | input | 24 | Absolute address field |
| wide_space | input | 1 | 1 selects the 24-bit space, 0 the 16-bit space |
| load_en | input | 1 | Writes `load_value` into a register |
| load_reg | input | 3 | Register index for the load |
| load_value | input | 32 | Value to load |
| ea_valid | output | 1 | Result valid |
| ea | output | 24 | Effective address |
| wb_strobe | output | 1 | Register writeback happened |
| wb_value | output | 32 | Value written back |
| misalign | output | 1 | Alignment violation |

## Verification
The bench builds the block with its default parameters: eight registers, 32-bit registers, a 24-bit address and a 16-bit reduced space. This makes the extension boundaries of the absolute forms reachable, such as 0x7FFF against 0x8000. It also reaches the 32-bit wrap of the stepped register from both directions. Chained requests on one register exercise both the read-after-writeback path and the two alignment rules.

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int AW   = 24,
  parameter int NW   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_mode,
  input  logic [1:0]               req_size,
  input  logic [$clog2(NREG)-1:0]  req_reg,
  input  logic [AW-1:0]            req_field,
  input  logic                     wide_space,
  input  logic                     load_en,
  input  logic [$clog2(NREG)-1:0]  load_reg,
  input  logic [DW-1:0]            load_value,
  output logic                     ea_valid,
  output logic [AW-1:0]            ea,
  output logic                     wb_strobe,
  output logic [DW-1:0]            wb_value,
  output logic                     misalign
);
  localparam logic [2:0] M_POST = 3'd0, M_PRE = 3'd1, M_ABS8 = 3'd2, M_ABS16 = 3'd3;
  localparam logic [AW-1:0] NARROW_MASK = {{(AW-NW){1'b0}}, {NW{1'b1}}};

  logic [DW-1:0] rf [NREG];

  wire [DW-1:0] cur  = rf[req_reg];
  wire [DW-1:0] step = req_size[1] ? DW'(4) : req_size[0] ? DW'(2) : DW'(1);
  wire [DW-1:0] inc  = cur + step;
  wire [DW-1:0] dec  = cur - step;
  wire          post = (req_mode == M_POST);
  wire          pre  = (req_mode == M_PRE);
  wire          stepping = post | pre;
  wire [DW-1:0] nxt  = post ? inc : dec;
  wire          odd  = post ? cur[0] : dec[0];
  wire          bad  = stepping & (req_size != 2'd0) & odd;

  logic [AW-1:0] raw_ea;
  always_comb begin
    case (req_mode)
      M_POST:  raw_ea = cur[AW-1:0];
      M_PRE:   raw_ea = dec[AW-1:0];
      M_ABS8:  raw_ea = {{(AW-8){1'b1}}, req_field[7:0]};
      M_ABS16: raw_ea = {{(AW-16){req_field[15]}}, req_field[15:0]};
      default: raw_ea = req_field;
    endcase
  end

  wire [AW-1:0] next_ea = wide_space ? raw_ea : (raw_ea & NARROW_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (load_en) rf[load_reg] <= load_value;
      if (req_valid && stepping) rf[req_reg] <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_valid  <= 1'b0;
      ea        <= '0;
      wb_strobe <= 1'b0;
      wb_value  <= '0;
      misalign  <= 1'b0;
    end else begin
      ea_valid  <= req_valid;
      wb_strobe <= req_valid & stepping;
      misalign  <= req_valid & bad;
      if (req_valid) begin
        ea <= next_ea;
        if (stepping) wb_value <= nxt;
      end
    end
  end

  assert_abs_no_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode >= M_ABS8) |=> !wb_strobe);
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!ea_valid && !wb_strobe && !misalign));
  assert_narrow_top_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !wide_space) |=> (ea[AW-1:NW] == '0));
  assert_predec_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pre && wide_space) |=> (ea == wb_value[AW-1:0]));
  assert_postinc_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && post && wide_space && req_size == 2'd0) |=> (wb_value[AW-1:0] - ea == AW'(1)));
  assert_abs8_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == M_ABS8 && wide_space) |=> (ea[AW-1:8] == '1));
  assert_misalign_only_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> wb_strobe);
endmodule

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, wide_space = 0, load_en = 0, misalign, ea_valid, wb_strobe;
  logic [2:0] req_mode = 0, req_reg = 0, load_reg = 0;
  logic [1:0] req_size = 0;
  logic [23:0] req_field = 0, ea;
  logic [31:0] load_value = 0, wb_value;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ea_unit u0 (.clk, .rst_n, .req_valid, .req_mode, .req_size, .req_reg, .req_field,
    .wide_space, .load_en, .load_reg, .load_value, .ea_valid, .ea, .wb_strobe,
    .wb_value, .misalign);

  // {mode, wide, field, expected ea}
  localparam int NV = 10;
  localparam logic [51:0] VEC [NV] = '{
    {3'd2, 1'b1, 24'h123456, 24'hFFFF56},
    {3'd2, 1'b1, 24'h000000, 24'hFFFF00},
    {3'd2, 1'b0, 24'h0000AB, 24'h00FFAB},
    {3'd3, 1'b1, 24'h007FFF, 24'h007FFF},
    {3'd3, 1'b1, 24'h008000, 24'hFF8000},
    {3'd3, 1'b1, 24'h00ABCD, 24'hFFABCD},
    {3'd3, 1'b0, 24'h00ABCD, 24'h00ABCD},
    {3'd4, 1'b1, 24'h9ABCDE, 24'h9ABCDE},
    {3'd4, 1'b0, 24'h9ABCDE, 24'h00BCDE},
    {3'd5, 1'b1, 24'h123456, 24'h123456}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(logic [2:0] r, logic [31:0] v);
    @(negedge clk);
    load_en = 1; load_reg = r; load_value = v;
    @(negedge clk);
    load_en = 0;
  endtask

  task automatic req(string tag, logic [2:0] m, logic [1:0] s, logic [2:0] r,
                     logic [23:0] f, logic w, logic [23:0] x_ea, logic x_wb,
                     logic [31:0] x_val, logic x_mis);
    @(negedge clk);
    req_valid = 1; req_mode = m; req_size = s; req_reg = r; req_field = f; wide_space = w;
    @(negedge clk);
    req_valid = 0;
    check({tag, " R13 valid"}, 32'(ea_valid), 32'd1);
    check({tag, " ea"}, 32'(ea), 32'(x_ea));
    check({tag, " R11 strobe"}, 32'(wb_strobe), 32'(x_wb));
    if (x_wb) check({tag, " wb value"}, wb_value, x_val);
    check({tag, " R6 misalign"}, 32'(misalign), 32'(x_mis));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #5;
    check("R1 ea_valid", 32'(ea_valid), 0);
    check("R1 ea", 32'(ea), 0);
    check("R1 wb_strobe", 32'(wb_strobe), 0);
    check("R1 wb_value", wb_value, 0);
    check("R1 misalign", 32'(misalign), 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++)
      req($sformatf("R7/R8/R9/R10 vec%0d", i), VEC[i][51:49], 2'd0, 3'd0,
          VEC[i][47:24], VEC[i][48], VEC[i][23:0], 1'b0, 32'd0, 1'b0);

    req("R1 reg zero R2", 3'd0, 2'd0, 3'd3, 0, 1, 24'h000000, 1, 32'h00000001, 0);

    load(3'd1, 32'h00001000);
    req("R2 R3 word R12", 3'd0, 2'd1, 3'd1, 0, 1, 24'h001000, 1, 32'h00001002, 0);
    req("R2 R3 long R12", 3'd0, 2'd2, 3'd1, 0, 1, 24'h001002, 1, 32'h00001006, 0);
    req("R4 R3 byte", 3'd1, 2'd0, 3'd1, 0, 1, 24'h001005, 1, 32'h00001005, 0);
    req("R4 R6 odd result", 3'd1, 2'd2, 3'd1, 0, 1, 24'h001001, 1, 32'h00001001, 1);
    req("R2 R6 odd source", 3'd0, 2'd1, 3'd1, 0, 1, 24'h001001, 1, 32'h00001003, 1);
    req("R6 byte ok", 3'd0, 2'd0, 3'd1, 0, 1, 24'h001003, 1, 32'h00001004, 0);
    req("R3 size3", 3'd0, 2'd3, 3'd1, 0, 1, 24'h001004, 1, 32'h00001008, 0);

    load(3'd2, 32'hFFFFFFFF);
    req("R5 wrap up", 3'd0, 2'd0, 3'd2, 0, 1, 24'hFFFFFF, 1, 32'h00000000, 0);
    req("R5 wrap down", 3'd1, 2'd2, 3'd2, 0, 1, 24'hFFFFFC, 1, 32'hFFFFFFFC, 0);

    load(3'd4, 32'h12345678);
    req("R10 narrow post", 3'd0, 2'd2, 3'd4, 0, 0, 24'h005678, 1, 32'h1234567C, 0);
    req("R10 narrow pre", 3'd1, 2'd1, 3'd4, 0, 0, 24'h00567A, 1, 32'h1234567A, 0);

    @(negedge clk);
    check("R11 idle strobe", 32'(wb_strobe), 0);
    check("R13 idle valid", 32'(ea_valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule